// File: doc/BRIEF.md
# DMA Channel Control and Status

This block holds the control and status state of one channel of a simple DMA controller. Software sets it up through a small register port. The port gives access to a control word, a transfer counter and an 8-bit interrupt vector. The datapath reports each finished transfer with a one-cycle done strobe. The block answers with a transfer-active qualifier that says whether the channel may move data in the current cycle.

Transfers are gated by several conditions:
- the local channel enable;
- a global master enable;
- two global abort conditions: a non-maskable-interrupt abort and an address-error abort;
- the channel's own end flag.

In auto mode the channel runs whenever these gates allow. In request mode it also needs an external or peripheral request line to be high.

When the counter runs out, the end flag is set. The flag raises an interrupt request if the local interrupt enable allows it. Software can clear the flag only by reading it as 1 and then writing 0 to it. Two power inputs act on the registers. A standby input returns every register to its reset value. A module-standby input freezes all registers.

Top module: `dma_chan_ctl`

## Requirements
- R1: In auto mode (`mode_req_i`=0), `xfer_act_o` is 1 exactly when all of the following hold:
  - channel enable (CTRL bit 0) is 1;
  - `glb_en_i` is 1;
  - the end flag (CTRL bit 1) is 0;
  - `nmi_abort_i` is 0;
  - `addr_err_i` is 0;
  - the counter is nonzero.
- R2: In request mode (`mode_req_i`=1), `xfer_act_o` additionally requires `req_i`=1.
- R3: A `done_i` pulse decrements the counter by one only while the R1 gating holds. The pulse that takes the counter from 1 to 0 sets the end flag. When the gating does not hold, `done_i` leaves the counter unchanged.
- R4: Writing 0 to CTRL bit 0 drops `xfer_act_o` from the next cycle on.
- R5: A write to CTRL with bit 1 = 0 clears the end flag only if the end flag was armed by an earlier read. Any other write to CTRL leaves the end flag unchanged.
- R6: A read of CTRL (address 0) that returns bit 1 = 1 arms the clear. Any write to CTRL disarms it.
- R7: The vector register (address 2) keeps `reg_wdata[7:0]` and drives it on `vec_o`. Read bits 31..8 of the vector register are always 0.
- R8: `end_irq_o` is 1 exactly when the end flag is 1 and interrupt enable (CTRL bit 2) is 1.
- R9: Reset and `stby_i` return control, counter (address 1) and vector to 0.
- R10: While `mod_stby_i` is 1, no register changes, whether from writes or from `done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_i | input | 1 | Standby: returns registers to reset values |
| mod_stby_i | input | 1 | Module standby: freezes all registers |
| reg_addr | input | 2 | Register select: 0 control, 1 counter, 2 vector |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| glb_en_i | input | 1 | Global master enable |
| nmi_abort_i | input | 1 | Global NMI abort flag |
| addr_err_i | input | 1 | Global address-error flag |
| mode_req_i | input | 1 | 0 auto mode, 1 request mode |
| req_i | input | 1 | External or peripheral transfer request |
| done_i | input | 1 | One-cycle transfer-done strobe from the datapath |
| xfer_act_o | output | 1 | Channel may transfer this cycle |
| end_irq_o | output | 1 | Transfer-end interrupt request |
| vec_o | output | 8 | Interrupt vector number |

## Verification
The hardest state to reach from the ports is the armed clear. The end flag must already be set. A read must return it as 1. Only then may a write with bit 1 = 0 follow, and no other control write may come between them.

The stimulus first runs a counter to zero with done strobes. It then tries to clear the flag in three ways: with no read at all, with a read followed by a write that keeps bit 1 high, and with a read followed at once by a zero write. It watches `end_irq_o` after each write, because any extra read of the control register would itself arm the clear.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int VEC_W   = 8;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_END_BIT = 1;
    localparam int CTL_IE_BIT  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_CNT  = 2'd1,
        REG_VEC  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ie;
        logic end_flag;
        logic en;
    } ctl_state_t;

    typedef struct packed {
        logic wr_ctl;
        logic wr_cnt;
        logic wr_vec;
        logic rd_ctl;
    } reg_acc_t;

    function automatic reg_acc_t decode_acc(logic [ADDR_W-1:0] addr, logic wr, logic rd);
        reg_acc_t a;
        a.wr_ctl = wr && (addr == REG_CTRL);
        a.wr_cnt = wr && (addr == REG_CNT);
        a.wr_vec = wr && (addr == REG_VEC);
        a.rd_ctl = rd && !wr && (addr == REG_CTRL);
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_word(ctl_state_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_EN_BIT]  = s.en;
        w[CTL_END_BIT] = s.end_flag;
        w[CTL_IE_BIT]  = s.ie;
        return w;
    endfunction
endpackage

// File: rtl/dmach_ctl_reg.sv
module dmach_ctl_reg
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_i,
    input  logic              frz_i,
    input  reg_acc_t          acc_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              last_done_i,
    output ctl_state_t        st_o,
    output logic              armed_o
);
    ctl_state_t st_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (rst || stby_i) begin
            st_q    <= '0;
            armed_q <= 1'b0;
        end else if (!frz_i) begin
            if (acc_i.wr_ctl) begin
                st_q.en <= wdata_i[CTL_EN_BIT];
                st_q.ie <= wdata_i[CTL_IE_BIT];
                armed_q <= 1'b0;
                if (armed_q && !wdata_i[CTL_END_BIT])
                    st_q.end_flag <= 1'b0;
            end else if (acc_i.rd_ctl && st_q.end_flag) begin
                armed_q <= 1'b1;
            end
            if (last_done_i)
                st_q.end_flag <= 1'b1;
        end
    end

    assign st_o    = st_q;
    assign armed_o = armed_q;

    // R5: end flag only falls after an armed clear (or standby)
    p_end_clear_armed_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.end_flag) |-> ($past(armed_q) || $past(stby_i)));

    // R6: a control write always leaves the clear disarmed
    p_wr_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_i.wr_ctl && !frz_i) |=> !armed_q);

    // R10: module standby freezes control state
    p_ctl_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (frz_i && !stby_i) |=> ($stable(st_q) && $stable(armed_q)));
endmodule

// File: rtl/dmach_counter.sv
module dmach_counter
    import dmach_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_i,
    input  logic              frz_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              step_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              nonzero_o,
    output logic              last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || stby_i)
            cnt_q <= '0;
        else if (!frz_i) begin
            if (wr_i)
                cnt_q <= wdata_i[CNT_W-1:0];
            else if (step_i && cnt_q != '0)
                cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o     = cnt_q;
    assign nonzero_o = (cnt_q != '0);
    assign last_o    = step_i && !wr_i && !frz_i && (cnt_q == ONE);

    // R3: each accepted step takes exactly one off the count
    p_step_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i && !wr_i && !frz_i && !stby_i) |=> (cnt_q == $past(cnt_q) - ONE));

    // R10: count frozen in module standby
    p_cnt_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (frz_i && !stby_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dmach_vector.sv
module dmach_vector
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_i,
    input  logic              frz_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [VEC_W-1:0]  vec_o
);
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst || stby_i)
            vec_q <= '0;
        else if (!frz_i && wr_i)
            vec_q <= wdata_i[VEC_W-1:0];
    end

    assign vec_o = vec_q;

    // R7: a write lands the low byte in the vector
    p_vec_load_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !frz_i && !stby_i) |=> (vec_q == $past(wdata_i[VEC_W-1:0])));
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dmach_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      stby_i,
    input  logic                      mod_stby_i,
    input  logic [dmach_pkg::ADDR_W-1:0] reg_addr,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [dmach_pkg::DATA_W-1:0] reg_wdata,
    output logic [dmach_pkg::DATA_W-1:0] reg_rdata,
    input  logic                      glb_en_i,
    input  logic                      nmi_abort_i,
    input  logic                      addr_err_i,
    input  logic                      mode_req_i,
    input  logic                      req_i,
    input  logic                      done_i,
    output logic                      xfer_act_o,
    output logic                      end_irq_o,
    output logic [dmach_pkg::VEC_W-1:0] vec_o
);
    reg_acc_t         acc;
    ctl_state_t       ctl;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             cnt_nz;
    logic             cnt_last;
    logic             gate_ok;
    logic             step;

    assign acc = decode_acc(reg_addr, reg_wr, reg_rd);

    assign gate_ok = ctl.en && glb_en_i && !ctl.end_flag &&
                     !nmi_abort_i && !addr_err_i && cnt_nz;
    assign step    = gate_ok && done_i;

    dmach_ctl_reg u_ctl (
        .clk        (clk),
        .rst        (rst),
        .stby_i     (stby_i),
        .frz_i      (mod_stby_i),
        .acc_i      (acc),
        .wdata_i    (reg_wdata),
        .last_done_i(cnt_last),
        .st_o       (ctl),
        .armed_o    (armed)
    );

    dmach_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .stby_i   (stby_i),
        .frz_i    (mod_stby_i),
        .wr_i     (acc.wr_cnt),
        .wdata_i  (reg_wdata),
        .step_i   (step),
        .cnt_o    (cnt),
        .nonzero_o(cnt_nz),
        .last_o   (cnt_last)
    );

    dmach_vector u_vec (
        .clk    (clk),
        .rst    (rst),
        .stby_i (stby_i),
        .frz_i  (mod_stby_i),
        .wr_i   (acc.wr_vec),
        .wdata_i(reg_wdata),
        .vec_o  (vec_o)
    );

    assign xfer_act_o = gate_ok && (!mode_req_i || req_i);
    assign end_irq_o  = ctl.end_flag && ctl.ie;

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            REG_CTRL: reg_rdata = ctl_word(ctl);
            REG_CNT:  reg_rdata = DATA_W'(cnt);
            REG_VEC:  reg_rdata = DATA_W'(vec_o);
            default:  reg_rdata = '0;
        endcase
    end

    // R1: no transfer while any abort or the end flag is up
    p_act_gated_r1: assert property (@(posedge clk) disable iff (rst)
        xfer_act_o |-> (glb_en_i && !nmi_abort_i && !addr_err_i && !end_irq_o));

    // R2: request mode needs a live request
    p_req_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_req_i && !req_i) |-> !xfer_act_o);

    // R8: interrupt only with the enable bit set
    p_irq_en_r8: assert property (@(posedge clk) disable iff (rst)
        end_irq_o |-> reg_sel_e'(2'd0) == REG_CTRL && ctl_word(ctl)[CTL_IE_BIT]);

    // R7: vector upper read bits are zero
    p_vec_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REG_VEC) |-> (reg_rdata[DATA_W-1:VEC_W] == '0));

    // R4: clearing the enable stops activity next cycle
    p_dis_stops_r4: assert property (@(posedge clk) disable iff (rst)
        (acc.wr_ctl && !mod_stby_i && !reg_wdata[CTL_EN_BIT]) |=> !xfer_act_o);
endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stby_i = 1'b0, mod_stby_i = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        glb_en_i = 1'b0, nmi_abort_i = 1'b0, addr_err_i = 1'b0;
    logic        mode_req_i = 1'b0, req_i = 1'b0, done_i = 1'b0;
    logic        xfer_act_o, end_irq_o;
    logic [7:0]  vec_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_chan_ctl i_dma_chan_ctl (
        .clk(clk), .rst(rst), .stby_i(stby_i), .mod_stby_i(mod_stby_i),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glb_en_i(glb_en_i), .nmi_abort_i(nmi_abort_i), .addr_err_i(addr_err_i),
        .mode_req_i(mode_req_i), .req_i(req_i), .done_i(done_i),
        .xfer_act_o(xfer_act_o), .end_irq_o(end_irq_o), .vec_o(vec_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(2'd0, d); check("R9 ctrl after reset", d, 32'h0);
        rd_reg(2'd1, d); check("R9 count after reset", d, 32'h0);
        rd_reg(2'd2, d); check("R9 vector after reset", d, 32'h0);
        check("R1 idle after reset", {31'b0, xfer_act_o}, 32'd0);
        check("R8 no irq after reset", {31'b0, end_irq_o}, 32'd0);
    endtask

    task automatic t_auto_run();
        logic [31:0] d;
        glb_en_i = 1'b1;
        wr_reg(2'd1, 32'd3);
        wr_reg(2'd2, 32'h5A);
        wr_reg(2'd0, 32'h5);
        #1 check("R1 auto active", {31'b0, xfer_act_o}, 32'd1);
        pulse_done(); pulse_done();
        rd_reg(2'd1, d); check("R3 count after two done", d, 32'd1);
        check("R8 no irq before end", {31'b0, end_irq_o}, 32'd0);
        pulse_done();
        #1 check("R3 end flag raises irq", {31'b0, end_irq_o}, 32'd1);
        check("R1 end flag blocks activity", {31'b0, xfer_act_o}, 32'd0);
        check("R7 vector output", {24'b0, vec_o}, 32'h5A);
    endtask

    task automatic t_end_clear();
        logic [31:0] d;
        wr_reg(2'd0, 32'h5);
        #1 check("R5 unarmed zero write keeps flag", {31'b0, end_irq_o}, 32'd1);
        rd_reg(2'd0, d); check("R6 ctrl reads end flag", d, 32'h7);
        wr_reg(2'd0, 32'h7);
        #1 check("R5 write of one keeps flag", {31'b0, end_irq_o}, 32'd1);
        wr_reg(2'd0, 32'h5);
        #1 check("R6 disarmed by earlier write", {31'b0, end_irq_o}, 32'd1);
        rd_reg(2'd0, d);
        wr_reg(2'd0, 32'h5);
        #1 check("R5 armed zero write clears", {31'b0, end_irq_o}, 32'd0);
        rd_reg(2'd0, d); check("R5 ctrl after clear", d, 32'h5);
    endtask

    task automatic t_gating();
        wr_reg(2'd1, 32'd5);
        #1 check("R1 active with count", {31'b0, xfer_act_o}, 32'd1);
        nmi_abort_i = 1'b1;
        #1 check("R1 nmi blocks", {31'b0, xfer_act_o}, 32'd0);
        nmi_abort_i = 1'b0; addr_err_i = 1'b1;
        #1 check("R1 address error blocks", {31'b0, xfer_act_o}, 32'd0);
        addr_err_i = 1'b0; glb_en_i = 1'b0;
        #1 check("R1 master enable blocks", {31'b0, xfer_act_o}, 32'd0);
        glb_en_i = 1'b1;
        #1 check("R1 active restored", {31'b0, xfer_act_o}, 32'd1);
    endtask

    task automatic t_request_and_stop();
        logic [31:0] d;
        mode_req_i = 1'b1; req_i = 1'b0;
        #1 check("R2 no request no activity", {31'b0, xfer_act_o}, 32'd0);
        req_i = 1'b1;
        #1 check("R2 request gives activity", {31'b0, xfer_act_o}, 32'd1);
        pulse_done();
        rd_reg(2'd1, d); check("R3 request-mode decrement", d, 32'd4);
        wr_reg(2'd0, 32'h4);
        #1 check("R4 disable stops activity", {31'b0, xfer_act_o}, 32'd0);
        pulse_done();
        rd_reg(2'd1, d); check("R3 no decrement when disabled", d, 32'd4);
        req_i = 1'b0; mode_req_i = 1'b0;
    endtask

    task automatic t_vector();
        logic [31:0] d;
        wr_reg(2'd2, 32'hFFFF_FFA5);
        rd_reg(2'd2, d); check("R7 upper bits read zero", d, 32'h0000_00A5);
        check("R7 vector output updated", {24'b0, vec_o}, 32'hA5);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        wr_reg(2'd0, 32'h1);
        @(negedge clk); mod_stby_i = 1'b1;
        pulse_done();
        wr_reg(2'd2, 32'h11);
        wr_reg(2'd0, 32'h0);
        @(negedge clk); mod_stby_i = 1'b0;
        rd_reg(2'd1, d); check("R10 count frozen", d, 32'd4);
        rd_reg(2'd2, d); check("R10 vector frozen", d, 32'hA5);
        rd_reg(2'd0, d); check("R10 ctrl frozen", d, 32'h1);
    endtask

    task automatic t_standby();
        logic [31:0] d;
        @(negedge clk); stby_i = 1'b1;
        @(negedge clk); stby_i = 1'b0;
        rd_reg(2'd0, d); check("R9 standby clears ctrl", d, 32'h0);
        rd_reg(2'd1, d); check("R9 standby clears count", d, 32'h0);
        rd_reg(2'd2, d); check("R9 standby clears vector", d, 32'h0);
        check("R9 idle after standby", {31'b0, xfer_act_o}, 32'd0);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_auto_run();
        t_end_clear();
        t_gating();
        t_request_and_stop();
        t_vector();
        t_freeze();
        t_standby();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule